// File: doc/BRIEF.md
# Block-Copy DMA Engine with Byte-Lane Reordering

This block is a single-channel copy engine. Software programs a source offset, a destination offset, a byte count and a control word, then pulses `start`. The engine reads one 32-bit word from the source region, optionally reorders its byte lanes, writes the word to the destination region, and repeats until the whole block has been copied. Each side names one of seven regions through a 3-bit device code: codes 0 to 4 are chip-select regions, 5 is SDRAM and 6 is internal RAM. Each side can advance by one word per transfer or stay on one address, which suits a FIFO-style peripheral.

Reads and writes share one request/ready memory port. A request holds its address, device and direction steady until `mem_ready` is seen high at a clock edge. The engine checks the setup when `start` arrives. A setup it cannot run is refused and `err` is raised. A finished copy is marked by a one-cycle `done` pulse.

Top module: `blk_copy_dma`

## Requirements
- R1: Configuration writes use `cfg_sel`: 0 sets the source offset, 1 the destination offset, 2 the byte count, and 3 the control word. The control word holds source-hold in bit 0, destination-hold in bit 1, the swap mode in bits 3:2, the source device in bits 6:4 and the destination device in bits 9:7.
- R2: A read request has `mem_we`=0, `mem_dev` equal to the source device and `mem_addr` equal to the current source address. Any request keeps its address, device and direction unchanged until it is accepted (`mem_req` and `mem_ready` both high at a rising edge).
- R3: The word written is the word read, reordered by the swap mode. Mode 0 leaves the word unchanged. Mode 1 exchanges the two bytes inside each 16-bit half. Mode 2 exchanges the two 16-bit halves. Mode 3 reverses all four bytes.
- R4: When its hold bit is clear, an address starts at the programmed offset and advances by 4 after each accepted access on that side. When the hold bit is set, the address stays on the offset. Every address presented is a multiple of 4.
- R5: An accepted start performs exactly byte-count/4 read-then-write pairs. The destination device code is driven on writes.
- R6: A start is refused when either offset is not a multiple of 4, the byte count is zero or not a multiple of 4, or either device code is 7. A refused start sets `err`, leaves `busy` low and issues no memory request. An accepted start clears `err`.
- R7: `done` is high for exactly one cycle, in the cycle after the final write is accepted. `busy` falls at the same edge.
- R8: A start pulse while `busy` is high is ignored, including one in the same cycle as the final write acceptance. The transfer count and `err` are not changed, and no further transfer follows.
- R9: The offsets, byte count and control word are captured when a start is accepted. Configuration writes during a transfer take effect only for the next start.
- R10: After reset, `busy`, `done`, `err` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | DW | Configuration write data |
| start | input | 1 | Start pulse |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start was refused |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_dev | output | 3 | Target region code |
| mem_addr | output | AW | Byte offset within the region |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid while mem_ready is high |
| mem_ready | input | 1 | Access accepted this cycle |

## Verification
The delicate overlap is between a new start pulse and the acceptance of the final write of a running copy. Both land on the same clock edge, at which `busy` is still high, so the start must be dropped while `done` fires. The bench's memory model raises `start` in exactly the cycle it grants the last write. It then judges that a single `done` was seen, that `busy` stays low and that no further request appears. A second overlap, configuration writes during a running copy, is judged by the write count and the destination contents matching the setup captured at start.

// File: rtl/dma_pkg.sv
// Shared types for the block-copy DMA engine.
// Assumes a 10-bit control word whose field positions are visible to software.
package dma_pkg;

    // Swap mode: bit 0 exchanges bytes within halves, bit 1 exchanges halves.
    typedef enum logic [1:0] {
        SWP_NONE       = 2'd0,
        SWP_HALF_BYTES = 2'd1,
        SWP_HALVES     = 2'd2,
        SWP_FULL       = 2'd3
    } swap_mode_e;

    // Control word, packed MSB first: dst_dev[9:7] src_dev[6:4] swap[3:2] dst_hold[1] src_hold[0]
    typedef struct packed {
        logic [2:0] dst_dev;
        logic [2:0] src_dev;
        swap_mode_e swap;
        logic       dst_hold;
        logic       src_hold;
    } xfer_ctl_t;

    localparam int          CTL_W       = $bits(xfer_ctl_t);
    localparam logic [2:0]  DEV_INVALID = 3'd7;

endpackage

// File: rtl/dma_cfg_regs.sv
// Configuration register file for the copy engine.
// Holds source offset, destination offset, byte count and control word.
// Assumes AW, SW and CTL_W are no wider than DW.
module dma_cfg_regs
    import dma_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32,
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [AW-1:0] src_off,
    output logic [AW-1:0] dst_off,
    output logic [SW-1:0] byte_cnt,
    output xfer_ctl_t     ctl
);

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_SIZE = 2'd2;
    localparam logic [1:0] SEL_CTL  = 2'd3;

    // Capture a software write into the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_off  <= '0;
            dst_off  <= '0;
            byte_cnt <= '0;
            ctl      <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_SRC:  src_off  <= wr_data[AW-1:0];
                SEL_DST:  dst_off  <= wr_data[AW-1:0];
                SEL_SIZE: byte_cnt <= wr_data[SW-1:0];
                SEL_CTL:  ctl      <= xfer_ctl_t'(wr_data[CTL_W-1:0]);
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/dma_addr_gen.sv
// Address counter for one side of the copy.
// Loads the programmed offset at start, then steps by STEP per accepted
// access unless the hold flag is set.
module dma_addr_gen #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          hold,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    // Load on start, advance on each accepted access when not held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= load_val;
        else if (step && !hold)
            addr <= addr + STEP_V;
    end

    // R4: a held address does not move on an accepted access.
    assert_hold_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && hold && !load) |=> (addr == $past(addr)));

    // R4: a free-running address moves by exactly one stride.
    assert_step_stride_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hold && !load) |=> (addr == $past(addr) + STEP_V));

endmodule

// File: rtl/dma_swap.sv
// Byte-lane reorder unit (combinational).
// Output lane b takes input lane (b XOR mode), so mode bit 0 swaps bytes
// within each 16-bit half and mode bit 1 swaps the halves.
// Assumes DW is a multiple of 32.
module dma_swap
    import dma_pkg::*;
#(
    parameter int DW = 32
) (
    input  swap_mode_e    mode,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    localparam int LANES = DW / 8;
    localparam int LIDX  = $clog2(LANES);

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [LIDX-1:0] src_lane;
        // Pick the source lane for this output byte.
        always_comb begin
            src_lane = LIDX'(b) ^ LIDX'(mode);
            dout[8*b +: 8] = din[{src_lane, 3'b000} +: 8];
        end
    end

endmodule

// File: rtl/dma_engine.sv
// Sequencer for the copy: validates a start, captures the setup, then
// alternates one read and one write on the shared port per word.
// Assumes mem_rdata is valid in the cycle mem_ready is high on a read.
module dma_engine
    import dma_pkg::*;
#(
    parameter int DW = 32,
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    src_lo,
    input  logic [1:0]    dst_lo,
    input  logic [SW-1:0] byte_cnt,
    input  xfer_ctl_t     ctl,
    input  logic          mem_ready,
    input  logic [DW-1:0] swapped_rdata,
    output swap_mode_e    swap_sel,
    output logic          addr_load,
    output logic          src_step,
    output logic          dst_step,
    output logic          src_hold,
    output logic          dst_hold,
    output logic          mem_req,
    output logic          mem_we,
    output logic [2:0]    mem_dev,
    output logic [DW-1:0] wdata,
    output logic          busy,
    output logic          done,
    output logic          err
);

    localparam int           LW      = SW - 2;
    localparam logic [LW-1:0] ONE_W  = LW'(1);

    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} state_e;

    state_e          state_q;
    xfer_ctl_t       ctl_q;
    logic [LW-1:0]   left_q;
    logic [DW-1:0]   data_q;
    logic            done_q;
    logic            err_q;
    logic            bad_setup;
    logic            last_accept;

    // Decide whether the programmed setup can be run.
    always_comb begin
        bad_setup = (src_lo != 2'b00) || (dst_lo != 2'b00) ||
                    (byte_cnt == '0) || (byte_cnt[1:0] != 2'b00) ||
                    (ctl.src_dev == DEV_INVALID) || (ctl.dst_dev == DEV_INVALID);
    end

    // Sequence the transfer and keep the result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctl_q   <= '0;
            left_q  <= '0;
            data_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        err_q <= bad_setup;
                        if (!bad_setup) begin
                            state_q <= ST_READ;
                            ctl_q   <= ctl;
                            left_q  <= byte_cnt[SW-1:2];
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ready) begin
                        data_q  <= swapped_rdata;
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_ready) begin
                        left_q <= left_q - ONE_W;
                        if (left_q == ONE_W) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= ST_READ;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory port, address steps and status outputs.
    always_comb begin
        mem_req     = (state_q != ST_IDLE);
        mem_we      = (state_q == ST_WRITE);
        mem_dev     = mem_we ? ctl_q.dst_dev : ctl_q.src_dev;
        wdata       = data_q;
        swap_sel    = ctl_q.swap;
        src_hold    = ctl_q.src_hold;
        dst_hold    = ctl_q.dst_hold;
        addr_load   = (state_q == ST_IDLE) && start && !bad_setup;
        src_step    = (state_q == ST_READ) && mem_ready;
        dst_step    = (state_q == ST_WRITE) && mem_ready;
        last_accept = dst_step && (left_q == ONE_W);
        busy        = (state_q != ST_IDLE);
        done        = done_q;
        err         = err_q;
    end

    // R2: a pending request keeps its direction and device.
    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_dev)));

    // R6: a refused start leaves the engine idle with the error raised.
    assert_refused_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && bad_setup) |=> (!busy && err));

    // R7: done is a single pulse that follows the fall of busy.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a start while busy neither ends the transfer nor touches err.
    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !last_accept) |=> busy);
    assert_busy_start_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> $stable(err));

endmodule

// File: rtl/blk_copy_dma.sv
// Top of the block-copy DMA engine: configuration registers, two address
// counters, the lane reorder unit and the sequencer around one memory port.
// Assumes the memory side accepts one access per mem_ready pulse.
module blk_copy_dma
    import dma_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32,
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [2:0]    mem_dev,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready
);

    localparam int STEP = DW / 8;

    logic [AW-1:0] src_off, dst_off, src_addr, dst_addr;
    logic [SW-1:0] byte_cnt;
    xfer_ctl_t     ctl;
    swap_mode_e    swap_sel;
    logic [DW-1:0] swapped;
    logic          addr_load, src_step, dst_step, src_hold, dst_hold;

    dma_cfg_regs #(.DW(DW), .AW(AW), .SW(SW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_sel   (cfg_sel),
        .wr_data  (cfg_wdata),
        .src_off  (src_off),
        .dst_off  (dst_off),
        .byte_cnt (byte_cnt),
        .ctl      (ctl)
    );

    dma_addr_gen #(.AW(AW), .STEP(STEP)) u_src_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_load),
        .load_val (src_off),
        .step     (src_step),
        .hold     (src_hold),
        .addr     (src_addr)
    );

    dma_addr_gen #(.AW(AW), .STEP(STEP)) u_dst_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_load),
        .load_val (dst_off),
        .step     (dst_step),
        .hold     (dst_hold),
        .addr     (dst_addr)
    );

    dma_swap #(.DW(DW)) u_swap (
        .mode (swap_sel),
        .din  (mem_rdata),
        .dout (swapped)
    );

    dma_engine #(.DW(DW), .SW(SW)) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .src_lo        (src_off[1:0]),
        .dst_lo        (dst_off[1:0]),
        .byte_cnt      (byte_cnt),
        .ctl           (ctl),
        .mem_ready     (mem_ready),
        .swapped_rdata (swapped),
        .swap_sel      (swap_sel),
        .addr_load     (addr_load),
        .src_step      (src_step),
        .dst_step      (dst_step),
        .src_hold      (src_hold),
        .dst_hold      (dst_hold),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_dev       (mem_dev),
        .wdata         (mem_wdata),
        .busy          (busy),
        .done          (done),
        .err           (err)
    );

    // Present the address of whichever side the current access targets.
    always_comb begin
        mem_addr = mem_we ? dst_addr : src_addr;
    end

    // R4: every address on the port is word aligned.
    assert_addr_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R2: a pending request keeps its address.
    assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> $stable(mem_addr));

    // R10: no request while idle.
    assert_idle_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

endmodule

// File: tb/blk_copy_dma_tb.sv
// Self-checking bench: bench memory model with random ready, directed and
// random copies, refused setups, and start collisions.
module blk_copy_dma_tb_top;

    localparam int DW = 32;
    localparam int AW = 32;
    localparam int SW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          start = 1'b0;
    logic          busy, done, err;
    logic          mem_req, mem_we;
    logic [2:0]    mem_dev;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ready = 1'b0;

    always #4 clk = ~clk;

    blk_copy_dma #(.DW(DW), .AW(AW), .SW(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start(start), .busy(busy), .done(done),
        .err(err), .mem_req(mem_req), .mem_we(mem_we), .mem_dev(mem_dev),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem  [0:7][0:63];
    logic [31:0] expm [0:7][0:63];

    int          wr_cnt, rd_cnt, done_cnt;
    bit          rd_ok, wr_ok, any_req;
    logic [31:0] exp_rd_addr, exp_wr_addr;
    bit          exp_sf, exp_df;
    logic [2:0]  exp_sdev, exp_ddev;
    int          exp_words;
    bit          collide_arm = 0, collide_clr = 0;
    logic        rdy;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] ref_swap(input logic [31:0] w, input logic [1:0] m);
        logic [7:0] b0, b1, b2, b3;
        b0 = w[7:0]; b1 = w[15:8]; b2 = w[23:16]; b3 = w[31:24];
        case (m)
            2'd0:    return w;
            2'd1:    return {b2, b3, b0, b1};
            2'd2:    return {b1, b0, b3, b2};
            default: return {b0, b1, b2, b3};
        endcase
    endfunction

    // Memory model: decide ready and act on the access that the next edge accepts.
    always @(negedge clk) begin
        if (collide_clr) begin
            start = 1'b0;
            collide_clr = 0;
        end
        if (done) done_cnt++;
        if (mem_req) any_req = 1;
        if (mem_req && rst_n) begin
            rdy = (($urandom % 4) != 0);
            mem_ready = rdy;
            mem_rdata = mem[mem_dev][mem_addr[7:2]];
            if (rdy) begin
                if (mem_we) begin
                    if (mem_dev !== exp_ddev || mem_addr !== exp_wr_addr) wr_ok = 0;
                    mem[mem_dev][mem_addr[7:2]] = mem_wdata;
                    wr_cnt++;
                    if (!exp_df) exp_wr_addr += 4;
                    if (collide_arm && wr_cnt == exp_words) begin
                        start = 1'b1;
                        collide_arm = 0;
                        collide_clr = 1;
                    end
                end else begin
                    if (mem_dev !== exp_sdev || mem_addr !== exp_rd_addr) rd_ok = 0;
                    rd_cnt++;
                    if (!exp_sf) exp_rd_addr += 4;
                end
            end
        end else begin
            mem_ready = 1'b0;
            mem_rdata = '0;
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // R1: control word layout dst_dev[9:7] src_dev[6:4] swap[3:2] dst_hold[1] src_hold[0].
    function automatic logic [31:0] ctl_word(input bit sf, input bit df, input logic [1:0] sw,
                                             input logic [2:0] sd, input logic [2:0] dd);
        return {22'd0, dd, sd, sw, df, sf};
    endfunction

    task automatic wait_done(input int dc0);
        int t = 0;
        while (done_cnt == dc0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
    endtask

    // variant: 0 plain, 1 preset pattern, 2 start mid-run, 3 rewrite mid-run, 4 start on last write
    task automatic run_xfer(input int sidx, input int didx, input int words, input bit sf, input bit df,
                            input logic [1:0] sw, input logic [2:0] sd, input logic [2:0] dd, input int variant);
        int dc0;
        for (int dv = 0; dv < 8; dv++)
            for (int ix = 0; ix < 64; ix++)
                mem[dv][ix] = $urandom;
        if (variant == 1) mem[sd][sidx] = 32'h11223344;
        for (int dv = 0; dv < 8; dv++)
            for (int ix = 0; ix < 64; ix++)
                expm[dv][ix] = mem[dv][ix];
        for (int k = 0; k < words; k++)
            expm[dd][didx + (df ? 0 : k)] = ref_swap(mem[sd][sidx + (sf ? 0 : k)], sw);
        // R1: register selects 0 source, 1 destination, 2 byte count, 3 control.
        cfg_write(2'd0, 32'(sidx * 4));
        cfg_write(2'd1, 32'(didx * 4));
        cfg_write(2'd2, 32'(words * 4));
        cfg_write(2'd3, ctl_word(sf, df, sw, sd, dd));
        wr_cnt = 0; rd_cnt = 0; rd_ok = 1; wr_ok = 1;
        exp_rd_addr = 32'(sidx * 4); exp_wr_addr = 32'(didx * 4);
        exp_sf = sf; exp_df = df; exp_sdev = sd; exp_ddev = dd; exp_words = words;
        dc0 = done_cnt;
        if (variant == 4) collide_arm = 1;
        pulse_start();
        chk(busy == 1'b1, "R5 busy after accepted start", 32'(busy), 32'd1);
        if (variant == 2) begin
            repeat (3) @(negedge clk);
            pulse_start();   // R8: ignored while busy
        end
        if (variant == 3) begin
            // R9: new setup written during the run must not affect it
            cfg_write(2'd2, 32'd256);
            cfg_write(2'd3, ctl_word(~sf, ~df, ~sw, dd, sd));
        end
        wait_done(dc0);
        @(negedge clk);
        chk(wr_cnt == words, variant == 3 ? "R9 write count uses captured size" : "R5 write count",
            32'(wr_cnt), 32'(words));
        chk(rd_cnt == words, "R5 read count", 32'(rd_cnt), 32'(words));
        chk(rd_ok, "R2 read device/address sequence", 32'(rd_ok), 32'd1);
        chk(wr_ok, "R4 write device/address sequence", 32'(wr_ok), 32'd1);
        begin
            bit ok = 1;
            logic [31:0] a = '0, e = '0;
            for (int dv = 0; dv < 8; dv++)
                for (int ix = 0; ix < 64; ix++)
                    if (ok && mem[dv][ix] !== expm[dv][ix]) begin
                        ok = 0; a = mem[dv][ix]; e = expm[dv][ix];
                    end
            chk(ok, variant == 3 ? "R9 data uses captured control" : "R3 copied data", a, e);
        end
        chk(done_cnt == dc0 + 1 && !busy, "R7 single done, busy low", 32'(done_cnt - dc0), 32'd1);
        chk(err == 1'b0, "R6 err clear after accepted start", 32'(err), 32'd0);
        if (variant == 4) begin
            any_req = 0;
            repeat (4) @(negedge clk);
            chk(!busy && !any_req && done_cnt == dc0 + 1, "R8 start on final write ignored",
                {30'd0, busy, any_req}, 32'd0);
        end
    endtask

    task automatic try_bad(input logic [31:0] s, input logic [31:0] d, input logic [31:0] sz,
                           input logic [2:0] sd, input logic [2:0] dd, input string why);
        cfg_write(2'd0, s);
        cfg_write(2'd1, d);
        cfg_write(2'd2, sz);
        cfg_write(2'd3, ctl_word(0, 0, 2'd0, sd, dd));
        any_req = 0;
        pulse_start();
        repeat (3) @(negedge clk);
        chk(err && !busy && !any_req, why, {29'd0, err, busy, any_req}, 32'd4);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        done_cnt = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk({busy, done, err, mem_req} == 4'b0000, "R10 reset outputs",
            {28'd0, busy, done, err, mem_req}, 32'd0);

        // R3: directed swap modes on a known word
        run_xfer(3, 9, 1, 0, 0, 2'd0, 3'd0, 3'd5, 1);
        chk(mem[5][9] == 32'h11223344, "R3 mode 0 no swap", mem[5][9], 32'h11223344);
        run_xfer(3, 9, 1, 0, 0, 2'd1, 3'd1, 3'd6, 1);
        chk(mem[6][9] == 32'h22114433, "R3 mode 1 bytes in halves", mem[6][9], 32'h22114433);
        run_xfer(3, 9, 1, 0, 0, 2'd2, 3'd6, 3'd2, 1);
        chk(mem[2][9] == 32'h33441122, "R3 mode 2 halves", mem[2][9], 32'h33441122);
        run_xfer(3, 9, 1, 0, 0, 2'd3, 3'd4, 3'd3, 1);
        chk(mem[3][9] == 32'h44332211, "R3 mode 3 full reverse", mem[3][9], 32'h44332211);

        // R4: directed hold combinations
        run_xfer(0, 10, 6, 1, 0, 2'd0, 3'd2, 3'd5, 0);
        run_xfer(5, 40, 6, 0, 1, 2'd3, 3'd5, 3'd0, 0);
        run_xfer(7, 7, 5, 1, 1, 2'd1, 3'd6, 3'd1, 0);

        // Random copies
        for (int n = 0; n < 12; n++) begin
            int sdv, ddv;
            sdv = $urandom % 7;
            ddv = (sdv + 1 + ($urandom % 6)) % 7;
            run_xfer($urandom % 32, $urandom % 32, 1 + ($urandom % 16), $urandom % 2, $urandom % 2,
                     2'($urandom % 4), 3'(sdv), 3'(ddv), 0);
        end

        // R6: refused setups
        try_bad(32'h2, 32'h0, 32'd8, 3'd0, 3'd1, "R6 misaligned source");
        try_bad(32'h0, 32'h1, 32'd8, 3'd0, 3'd1, "R6 misaligned destination");
        try_bad(32'h0, 32'h8, 32'd0, 3'd0, 3'd1, "R6 zero size");
        try_bad(32'h0, 32'h8, 32'd6, 3'd0, 3'd1, "R6 size not multiple of 4");
        try_bad(32'h0, 32'h8, 32'd8, 3'd7, 3'd1, "R6 invalid source device");
        try_bad(32'h0, 32'h8, 32'd8, 3'd2, 3'd7, "R6 invalid destination device");
        run_xfer(1, 20, 3, 0, 0, 2'd2, 3'd3, 3'd4, 0);  // R6: err cleared by accepted start

        // R8: start pulse mid-transfer
        run_xfer(2, 30, 8, 0, 0, 2'd1, 3'd0, 3'd6, 2);
        // R9: rewrite configuration mid-transfer
        run_xfer(4, 12, 8, 0, 0, 2'd3, 3'd5, 3'd1, 3);
        // R8: start in the cycle of final write acceptance
        run_xfer(6, 33, 4, 0, 0, 2'd0, 3'd1, 3'd2, 4);
        run_xfer(0, 0, 1, 1, 1, 2'd2, 3'd4, 3'd0, 4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule